// File: doc/BRIEF.md
# Leakage-Aware ALU Power-Enable Controller

This controller sets how many of the four ALUs of a four-issue core stay powered and which of them are switched off. Every cycle it is told how many instructions were ready to issue, which is a measure of demand rather than of what actually issued. It takes that count on one cycle out of every few, saturates it at the issue width and adds a fixed number of samples into a window sum. The completed window sum is compared directly with a set of thresholds that are pre-scaled by the window length, so no divider is needed. The result is a count of ALUs to keep powered, from one to four.

On a slow epoch boundary the controller also reads one live leakage sensor value per ALU. It switches off the required number of ALUs, starting with the one whose reading is highest. The per-ALU enables and a one-cycle `decision_valid` pulse are registered outputs. Between epoch boundaries the enables do not move. Sleep-transistor sequencing, wake-up latency and issue steering are left to the surrounding logic.

Top module: `fu_gate_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, all bits of `alu_en` are 1 and `decision_valid` is 0.
- R2: `decision_valid` is high for exactly one cycle after every `EPOCH_CYCLES` rising edges counted from reset release. `alu_en` changes only in a cycle where `decision_valid` is high, whatever the sensor and ready inputs do in between.
- R3: Any `ready_cnt` value above 4 counts as 4 when it is added to the window.
- R4: `ready_cnt` is sampled only on rising edges 1, 1+`SAMPLE_STRIDE`, 1+2·`SAMPLE_STRIDE`, and so on, counted from reset release. Its value on every other edge has no effect.
- R5: A window closes after `NUM_SAMPLES` samples, and its sum replaces the held window sum. A decision uses the most recently closed window, or zero if no window has closed since reset.
- R6: The number of ALUs kept on is 1 plus the number of thresholds that the held window sum strictly exceeds. `thresh` holds the thresholds as three `SUM_W`-bit fields, lowest field first, and they must be in ascending order. A sum equal to a threshold does not exceed it.
- R7: When G ALUs must be switched off, the ALUs switched off are the G ALUs with the highest `leak_sense` readings at the decision edge. ALU i's reading is `leak_sense[i*SENSOR_W +: SENSOR_W]`.
- R8: Equal readings are ranked so that the ALU with the higher index is switched off first. Every decision leaves at least one ALU powered, even when all readings are equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ready_cnt | input | 3 | Number of instructions ready to issue this cycle |
| leak_sense | input | NUM_ALU*SENSOR_W | Leakage reading per ALU; ALU i at bits i*SENSOR_W upward |
| thresh | input | (NUM_ALU-1)*SUM_W | Window-scaled thresholds, lowest field first |
| alu_en | output | NUM_ALU | Registered power enable per ALU, 1 = powered |
| decision_valid | output | 1 | One-cycle pulse marking an update of `alu_en` |

## Verification
The bench builds the controller with an eight-sample window and a 100-cycle epoch while keeping the default stride of four. With these values the window sum stays below 33, so a window closes well inside each epoch, and every keep count from one to four is reached within a few hundred cycles. Because the thresholds are small, the bench can place a window sum exactly on a threshold, make saturation decide the outcome by raising the top threshold above the saturated maximum, and feed large values only on the cycles between samples. A behavioural model that ranks the ALUs by repeatedly picking the maximum reading is compared with the outputs on every cycle, including the cases with tied and all-equal sensor readings.

// File: rtl/fu_gate_pkg.sv
package fu_gate_pkg;
    localparam int ISSUE_MAX = 4;
    localparam int READY_W   = 3;

    function automatic logic [READY_W-1:0] clamp_ready(input logic [READY_W-1:0] v);
        return (v > READY_W'(ISSUE_MAX)) ? READY_W'(ISSUE_MAX) : v;
    endfunction
endpackage

// File: rtl/fu_ready_window.sv
module fu_ready_window
    import fu_gate_pkg::*;
#(
    parameter int SAMPLE_STRIDE = 4,
    parameter int NUM_SAMPLES   = 128,
    parameter int SUM_W         = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [READY_W-1:0] ready_cnt,
    output logic [SUM_W-1:0]   win_sum
);
    localparam int PH_W  = (SAMPLE_STRIDE > 1) ? $clog2(SAMPLE_STRIDE) : 1;
    localparam int CNT_W = (NUM_SAMPLES > 1) ? $clog2(NUM_SAMPLES) : 1;

    typedef struct packed {
        logic [PH_W-1:0]  phase;
        logic [CNT_W-1:0] cnt;
        logic [SUM_W-1:0] acc;
        logic [SUM_W-1:0] hist;
    } win_t;

    win_t win_d, win_q;
    logic [SUM_W-1:0] addend;

    always_comb begin
        win_d  = win_q;
        addend = SUM_W'(clamp_ready(ready_cnt));
        win_d.phase = (win_q.phase == PH_W'(SAMPLE_STRIDE - 1)) ? '0 : win_q.phase + PH_W'(1);
        if (win_q.phase == '0) begin
            if (win_q.cnt == CNT_W'(NUM_SAMPLES - 1)) begin
                win_d.hist = win_q.acc + addend;
                win_d.acc  = '0;
                win_d.cnt  = '0;
            end else begin
                win_d.acc  = win_q.acc + addend;
                win_d.cnt  = win_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) win_q <= '0;
        else     win_q <= win_d;
    end

    assign win_sum = win_q.hist;

    // Partial sum never grows past (samples-1) saturated samples (R3)
    p_acc_bound_r3: assert property (@(posedge clk) disable iff (rst)
        win_q.acc <= SUM_W'((NUM_SAMPLES - 1) * ISSUE_MAX));

    // Accumulator moves only after a sampling-phase edge (R4)
    p_sample_phase_r4: assert property (@(posedge clk) disable iff (rst)
        !$stable(win_q.acc) |-> $past(win_q.phase) == '0);

    // Held sum changes only when a window closes (R5)
    p_hist_update_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(win_q.hist) |-> win_q.cnt == '0);
endmodule

// File: rtl/fu_epoch_timer.sv
module fu_epoch_timer #(
    parameter int EPOCH_CYCLES = 10000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int EP_W = (EPOCH_CYCLES > 1) ? $clog2(EPOCH_CYCLES) : 1;

    logic [EP_W-1:0] ep_d, ep_q;

    always_comb begin
        tick = (ep_q == EP_W'(EPOCH_CYCLES - 1));
        ep_d = tick ? '0 : ep_q + EP_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) ep_q <= '0;
        else     ep_q <= ep_d;
    end

    // Ticks are isolated single cycles (R2)
    p_tick_isolated_r2: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
endmodule

// File: rtl/fu_leak_rank.sv
module fu_leak_rank #(
    parameter int NUM_ALU  = 4,
    parameter int SENSOR_W = 8,
    localparam int KW      = $clog2(NUM_ALU + 1)
) (
    input  logic [NUM_ALU*SENSOR_W-1:0] leak_sense,
    input  logic [KW-1:0]               gate_n,
    output logic [NUM_ALU-1:0]          keep_mask
);
    for (genvar i = 0; i < NUM_ALU; i++) begin : g_alu
        logic [KW-1:0] beaten_by;
        logic [SENSOR_W-1:0] mine;
        always_comb begin
            mine      = leak_sense[i*SENSOR_W +: SENSOR_W];
            beaten_by = '0;
            for (int j = 0; j < NUM_ALU; j++) begin
                if (j != i) begin
                    if ((leak_sense[j*SENSOR_W +: SENSOR_W] > mine) ||
                        ((leak_sense[j*SENSOR_W +: SENSOR_W] == mine) && (j > i)))
                        beaten_by = beaten_by + KW'(1);
                end
            end
            keep_mask[i] = (beaten_by >= gate_n);
        end
    end

    // Ranks form a permutation, so exactly NUM_ALU-gate_n stay on (R7)
    always_comb begin
        p_rank_count_r7: assert ($countones(keep_mask) == NUM_ALU - int'(gate_n) || gate_n > KW'(NUM_ALU));
    end
endmodule

// File: rtl/fu_gate_ctrl.sv
module fu_gate_ctrl
    import fu_gate_pkg::*;
#(
    parameter int NUM_ALU       = 4,
    parameter int SENSOR_W      = 8,
    parameter int SAMPLE_STRIDE = 4,
    parameter int NUM_SAMPLES   = 128,
    parameter int EPOCH_CYCLES  = 10000,
    localparam int SUM_W        = $clog2(NUM_SAMPLES * ISSUE_MAX + 1)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [READY_W-1:0]             ready_cnt,
    input  logic [NUM_ALU*SENSOR_W-1:0]    leak_sense,
    input  logic [(NUM_ALU-1)*SUM_W-1:0]   thresh,
    output logic [NUM_ALU-1:0]             alu_en,
    output logic                           decision_valid
);
    localparam int KW = $clog2(NUM_ALU + 1);

    typedef struct packed {
        logic [NUM_ALU-1:0] en;
        logic               valid;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic [SUM_W-1:0]   win_sum;
    logic               tick;
    logic [KW-1:0]      keep;
    logic [KW-1:0]      gate_n;
    logic [NUM_ALU-1:0] keep_mask;

    fu_ready_window #(
        .SAMPLE_STRIDE(SAMPLE_STRIDE),
        .NUM_SAMPLES  (NUM_SAMPLES),
        .SUM_W        (SUM_W)
    ) u_window (
        .clk      (clk),
        .rst      (rst),
        .ready_cnt(ready_cnt),
        .win_sum  (win_sum)
    );

    fu_epoch_timer #(
        .EPOCH_CYCLES(EPOCH_CYCLES)
    ) u_epoch (
        .clk (clk),
        .rst (rst),
        .tick(tick)
    );

    fu_leak_rank #(
        .NUM_ALU (NUM_ALU),
        .SENSOR_W(SENSOR_W)
    ) u_rank (
        .leak_sense(leak_sense),
        .gate_n    (gate_n),
        .keep_mask (keep_mask)
    );

    always_comb begin
        keep = KW'(1);
        for (int k = 0; k < NUM_ALU - 1; k++) begin
            if (win_sum > thresh[k*SUM_W +: SUM_W]) keep = keep + KW'(1);
        end
        gate_n = KW'(NUM_ALU) - keep;

        ctl_d       = ctl_q;
        ctl_d.valid = tick;
        if (tick) ctl_d.en = keep_mask;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q.en    <= '1;
            ctl_q.valid <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign alu_en         = ctl_q.en;
    assign decision_valid = ctl_q.valid;

    // Enables move only alongside the decision pulse (R2)
    p_en_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !$stable(ctl_q.en) |-> ctl_q.valid);

    // Decision pulse lasts one cycle (R2)
    p_valid_single_r2: assert property (@(posedge clk) disable iff (rst)
        ctl_q.valid |=> !ctl_q.valid);

    // Powered count after a decision equals the threshold-derived keep count (R6)
    p_keep_count_r6: assert property (@(posedge clk) disable iff (rst)
        ctl_q.valid |-> $countones(ctl_q.en) == int'($past(keep)));

    // Never all ALUs off (R8)
    p_one_on_r8: assert property (@(posedge clk) disable iff (rst)
        ctl_q.en != '0);
endmodule

// File: tb/fu_gate_ctrl_test.sv
module fu_gate_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NA     = 4;
    localparam int SW     = 8;
    localparam int STRIDE = 4;
    localparam int NSAMP  = 8;
    localparam int EPOCH  = 100;
    localparam int TW     = $clog2(NSAMP * 4 + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [2:0] ready_cnt = '0;
    logic [NA*SW-1:0] leak_sense = '0;
    logic [(NA-1)*TW-1:0] thresh = '0;
    logic [NA-1:0] alu_en;
    logic decision_valid;

    always #(CLK_PERIOD/2) clk = ~clk;

    fu_gate_ctrl #(
        .NUM_ALU(NA), .SENSOR_W(SW), .SAMPLE_STRIDE(STRIDE),
        .NUM_SAMPLES(NSAMP), .EPOCH_CYCLES(EPOCH)
    ) uut (
        .clk(clk), .rst(rst), .ready_cnt(ready_cnt), .leak_sense(leak_sense),
        .thresh(thresh), .alu_en(alu_en), .decision_valid(decision_valid)
    );

    // Behavioural model
    int m_phase, m_cnt, m_acc, m_hist, m_ep;
    bit [NA-1:0] m_en;
    bit m_valid;
    int compared = 0;
    int mismatched = 0;
    bit finished = 0;
    string tag = "R1";

    function automatic int leak_of(int i);
        return int'(leak_sense[i*SW +: SW]);
    endfunction

    function automatic int th(int k);
        return int'(thresh[k*TW +: TW]);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_phase = 0; m_cnt = 0; m_acc = 0; m_hist = 0; m_ep = 0;
            m_en = '1; m_valid = 0;
        end else begin
            int s;
            m_valid = 0;
            if (m_ep == EPOCH - 1) begin
                int keepn, gate;
                keepn = 1;
                for (int k = 0; k < NA - 1; k++) if (m_hist > th(k)) keepn++;
                gate = NA - keepn;
                m_en = '1;
                for (int g = 0; g < gate; g++) begin
                    int best, bi;
                    best = -1; bi = 0;
                    for (int i = 0; i < NA; i++)
                        if (m_en[i] && leak_of(i) >= best) begin best = leak_of(i); bi = i; end
                    m_en[bi] = 0;
                end
                m_valid = 1;
            end
            m_ep = (m_ep + 1) % EPOCH;
            s = (ready_cnt > 4) ? 4 : int'(ready_cnt);
            if (m_phase == 0) begin
                m_acc += s;
                m_cnt++;
                if (m_cnt == NSAMP) begin m_hist = m_acc; m_acc = 0; m_cnt = 0; end
            end
            m_phase = (m_phase + 1) % STRIDE;
        end
    end

    task automatic compare();
        compared++;
        if (alu_en !== m_en || decision_valid !== m_valid) begin
            mismatched++;
            $display("FAIL %s t=%0t: alu_en=%b valid=%b expected alu_en=%b valid=%b",
                     tag, $time, alu_en, decision_valid, m_en, m_valid);
        end
    endtask

    function automatic logic [NA*SW-1:0] pack_leak(int a, int b, int c, int d);
        return {SW'(d), SW'(c), SW'(b), SW'(a)};
    endfunction

    // mode 0: constant ready; 1: only between samples; 2: cycling; 3: sensors jitter
    task automatic run(int cycles, int mode, logic [2:0] rdy);
        for (int n = 0; n < cycles; n++) begin
            case (mode)
                1: ready_cnt = (m_phase == 0) ? 3'd0 : 3'd7;
                2: ready_cnt = 3'(n % 8);
                3: begin
                    ready_cnt = rdy;
                    if (!m_valid && m_ep != EPOCH - 1)
                        leak_sense = pack_leak(n % 200, 199 - n % 200, 50, n % 17);
                   end
                default: ready_cnt = rdy;
            endcase
            @(negedge clk);
            compare();
        end
    endtask

    initial begin
        thresh = {TW'(24), TW'(16), TW'(8)};
        leak_sense = pack_leak(10, 50, 30, 20);
        // R1: reset state and first cycle after release
        tag = "R1";
        for (int n = 0; n < 3; n++) begin @(negedge clk); compare(); end
        rst = 1'b0;
        @(negedge clk); compare();
        // R3: saturation decides keep 3 (raw 7s would exceed 40), ALU1 leakiest
        tag = "R3";
        thresh = {TW'(40), TW'(16), TW'(8)};
        run(2 * EPOCH, 0, 3'd7);
        // R6: sum equal to middle threshold keeps two
        tag = "R6";
        thresh = {TW'(24), TW'(16), TW'(8)};
        run(2 * EPOCH, 0, 3'd2);
        // R4: non-sample cycles carry 7, sampled cycles carry 0 -> keep one
        tag = "R4";
        leak_sense = pack_leak(90, 5, 5, 5);
        run(2 * EPOCH, 1, 3'd0);
        // R8: all readings equal, keep only ALU0
        tag = "R8";
        leak_sense = pack_leak(7, 7, 7, 7);
        run(2 * EPOCH, 0, 3'd0);
        // R7: full load then keep three with ALU2 leakiest
        tag = "R7";
        leak_sense = pack_leak(1, 2, 200, 3);
        run(2 * EPOCH, 0, 3'd4);
        run(2 * EPOCH, 0, 3'd3);
        // R5: windows of varying content
        tag = "R5";
        leak_sense = pack_leak(40, 41, 40, 39);
        run(3 * EPOCH, 2, 3'd0);
        // R2: sensors move between decisions, enables must hold
        tag = "R2";
        run(3 * EPOCH, 3, 3'd3);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule